// File: doc/BRIEF.md
# Slave tag link controller

This block sequences the link layer of a slave tag in a low-rate impulse-radio network. It runs on hard bit decisions that arrive with a one-cycle bit strobe. It hunts for a base-station frame and counts off a fixed detection stretch. It then searches for a 13-bit sync word that marks where the information bits begin. It writes one block of received bits into a receive FIFO. After that it loads a transmit block from a show-ahead transmit FIFO and sends that block, most significant bit first, once the slot address matches.

When the transmit FIFO runs dry, the controller waits for a quiet guard interval of zero bits. It then receives the next block directly, without repeating the preamble hunt or the sync search. After that block it goes back to waiting for a slot. The preamble detector, slot address decoder, both FIFOs and the radio all sit outside this block.

Top module: `tag_link_ctrl`

## Requirements
- R1: After reset the phase output is 0 (hunt), and rxf_wr, txf_rd and tx_en are all low.
- R2: In hunt, a high pre_found moves the phase to 1 (detect). Detect lasts exactly 63 bit strobes and then moves to 2 (align). No receive FIFO write happens in hunt, detect or align.
- R3: In align, the last 13 strobed bits are compared against 1111100110101 (the leftmost bit is the oldest). A full match moves the phase to 3 (receive), and the next strobed bit is the first information bit.
- R4: If align sees 76 strobes (63 + 13) without a match, the phase returns to 0. A match on the 76th strobe still wins.
- R5: In receive, each strobe writes one bit. rxf_wr is high for one cycle, in the cycle after the strobe, and rxf_bit carries the strobed bit. After 128 writes the phase moves to 4 (slot wait, fresh block).
- R6: In phase 4 with no block held and the transmit FIFO not empty, txf_rd pulses for exactly one cycle and txf_data is taken as the next transmit block.
- R7: In phase 4 with a block held, a high slot_match moves the phase to 5 (send). slot_match has no effect while no block is held.
- R8: In send, tx_en is high and tx_bit presents the block most significant bit first, advancing one bit per strobe. After 128 strobes the phase goes back to 4.
- R9: In phase 4 with no block held and the transmit FIFO empty, the phase moves to 6 (slot wait, drained).
- R10: In phase 6, 20 consecutive strobes carrying 0 move the phase to 7 (refill). A strobe carrying 1 restarts the guard count.
- R11: In phase 7, 128 strobed bits are written to the receive FIFO in the same way as in receive, with no preamble or sync search. The phase then moves to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid bit decision |
| bit_val | input | 1 | Hard bit decision, valid with bit_stb |
| pre_found | input | 1 | Preamble detected by the front end |
| slot_match | input | 1 | Slot address for this tag has been received |
| txf_empty | input | 1 | Transmit FIFO holds no block |
| txf_data | input | 128 | Head block of the show-ahead transmit FIFO |
| rxf_wr | output | 1 | Receive FIFO write enable |
| rxf_bit | output | 1 | Receive FIFO write data |
| txf_rd | output | 1 | Transmit FIFO pop |
| tx_en | output | 1 | Transmit bit stream active |
| tx_bit | output | 1 | Current transmit bit |
| phase | output | 3 | Link phase code, as listed in the requirements |

## Verification
The bench goes after the edges of the sync window. A match that completes exactly on the 76th align strobe must enter receive. One strobe later, the abort must happen instead. An off-by-one counter would either lose the late frame or keep searching too long. A sync word with a single bit flipped must never lock, which would catch a partial or inverted compare. The guard run is broken by a single 1 after 10 zeros, and the bench then checks that 19 more zeros are not enough. A guard count that does not restart would leave early. Transmitted bits are compared with the loaded block in MSB-first order, and each block must be popped exactly once, so an LSB-first shifter or a double pop shows up as a bit mismatch.

// File: rtl/tag_link_pkg.sv
package tag_link_pkg;

  typedef enum logic [2:0] {
    PH_HUNT      = 3'd0,
    PH_DETECT    = 3'd1,
    PH_ALIGN     = 3'd2,
    PH_RECV      = 3'd3,
    PH_SLOT_RX   = 3'd4,
    PH_SEND      = 3'd5,
    PH_SLOT_TX   = 3'd6,
    PH_REFILL    = 3'd7
  } phase_t;

  // True when a zero-based strobe count sits on the final strobe of a run.
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  // Wider of two limits, used to size the shared counter.
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_counter.sv
module strobe_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sync_matcher.sv
module sync_matcher #(
  parameter int unsigned     LEN = 13,
  parameter logic [LEN-1:0]  PAT = 13'b1111100110101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic din,
  output logic match
);
  logic [LEN-2:0] hist;
  logic [LEN-1:0] window;

  assign window = {hist, din};
  assign match  = (window == PAT);

  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (clr)      hist <= '0;
    else if (shift_en) hist <= window[LEN-2:0];
  end
endmodule

// File: rtl/block_shifter.sv
module block_shifter #(
  parameter int unsigned N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] ld_data,
  input  logic         shift,
  output logic         msb
);
  logic [N-1:0] sr;

  assign msb = sr[N-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= ld_data;
    else if (shift) sr <= {sr[N-2:0], 1'b0};
  end
endmodule

// File: rtl/tag_link_ctrl.sv
module tag_link_ctrl
  import tag_link_pkg::*;
#(
  parameter int unsigned    DET_BITS   = 63,
  parameter int unsigned    BLOCK_BITS = 128,
  parameter int unsigned    GUARD_BITS = 20,
  parameter int unsigned    SYNC_LEN   = 13,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT = 13'b1111100110101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  input  logic                  pre_found,
  input  logic                  slot_match,
  input  logic                  txf_empty,
  input  logic [BLOCK_BITS-1:0] txf_data,
  output logic                  rxf_wr,
  output logic                  rxf_bit,
  output logic                  txf_rd,
  output logic                  tx_en,
  output logic                  tx_bit,
  output logic [2:0]            phase
);
  localparam int unsigned ALIGN_LIMIT = DET_BITS + SYNC_LEN;
  localparam int unsigned CMAX = max2(max2(BLOCK_BITS, ALIGN_LIMIT), GUARD_BITS);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  phase_t        st, nxt;
  logic [CW-1:0] cnt;
  logic          cnt_inc, guard_restart, cnt_clr;
  logic          held, load_blk, shift_blk;
  logic          sync_match, sync_hit, send_done, guard_done;
  logic          align_abort, rx_active;

  // named events for the checker
  assign rx_active   = (st == PH_RECV) || (st == PH_REFILL);
  assign sync_hit    = bit_stb && (st == PH_ALIGN) && sync_match;
  assign align_abort = bit_stb && (st == PH_ALIGN) && !sync_match
                       && at_last(32'(cnt), ALIGN_LIMIT);
  assign send_done   = bit_stb && (st == PH_SEND) && at_last(32'(cnt), BLOCK_BITS);
  assign guard_done  = bit_stb && (st == PH_SLOT_TX) && !bit_val
                       && at_last(32'(cnt), GUARD_BITS);

  always_comb begin
    nxt           = st;
    cnt_inc       = 1'b0;
    guard_restart = 1'b0;
    load_blk      = 1'b0;
    shift_blk     = 1'b0;
    unique case (st)
      PH_HUNT: if (pre_found) nxt = PH_DETECT;
      PH_DETECT: if (bit_stb) begin
        cnt_inc = 1'b1;
        if (at_last(32'(cnt), DET_BITS)) nxt = PH_ALIGN;
      end
      PH_ALIGN: if (bit_stb) begin
        if (sync_hit)         nxt = PH_RECV;
        else if (align_abort) nxt = PH_HUNT;
        else                  cnt_inc = 1'b1;
      end
      PH_RECV, PH_REFILL: if (bit_stb) begin
        cnt_inc = 1'b1;
        if (at_last(32'(cnt), BLOCK_BITS)) nxt = PH_SLOT_RX;
      end
      PH_SLOT_RX: begin
        if (!held) begin
          if (txf_empty) nxt = PH_SLOT_TX;
          else           load_blk = 1'b1;
        end else if (slot_match) begin
          nxt = PH_SEND;
        end
      end
      PH_SEND: if (bit_stb) begin
        shift_blk = 1'b1;
        cnt_inc   = 1'b1;
        if (send_done) nxt = PH_SLOT_RX;
      end
      PH_SLOT_TX: if (bit_stb) begin
        if (bit_val)         guard_restart = 1'b1;
        else if (guard_done) nxt = PH_REFILL;
        else                 cnt_inc = 1'b1;
      end
      default: nxt = PH_HUNT;
    endcase
  end

  assign cnt_clr = (nxt != st) || guard_restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_HUNT;
      held    <= 1'b0;
      rxf_wr  <= 1'b0;
      rxf_bit <= 1'b0;
    end else begin
      st      <= nxt;
      rxf_wr  <= bit_stb && rx_active;
      rxf_bit <= bit_stb ? bit_val : 1'b0;
      if (load_blk)       held <= 1'b1;
      else if (send_done) held <= 1'b0;
    end
  end

  strobe_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  sync_matcher #(.LEN(SYNC_LEN), .PAT(SYNC_PAT)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(st == PH_HUNT),
    .shift_en(bit_stb && ((st == PH_DETECT) || (st == PH_ALIGN))),
    .din(bit_val), .match(sync_match)
  );

  block_shifter #(.N(BLOCK_BITS)) u_txsr (
    .clk(clk), .rst_n(rst_n), .load(load_blk), .ld_data(txf_data),
    .shift(shift_blk), .msb(tx_bit)
  );

  assign txf_rd = load_blk;
  assign tx_en  = (st == PH_SEND);
  assign phase  = st;

endmodule

// File: rtl/tag_link_chk.sv
module tag_link_chk
  import tag_link_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic       bit_val,
  input logic       slot_match,
  input logic       rxf_wr,
  input logic       txf_rd,
  input logic       tx_en,
  input logic [2:0] phase,
  input logic       sync_hit
);
  // R2
  align_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ALIGN && $past(phase) != PH_ALIGN) |-> $past(phase) == PH_DETECT);
  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECV && $past(phase) == PH_ALIGN) |-> $past(sync_hit));
  // R4
  abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HUNT && $past(phase) == PH_ALIGN) |-> ($past(bit_stb) && !$past(sync_hit)));
  // R5
  rx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_wr |-> ($past(bit_stb) && ($past(phase) == PH_RECV || $past(phase) == PH_REFILL)));
  // R6
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_rd |=> !txf_rd);
  // R7
  send_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(slot_match));
  // R10
  guard_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REFILL && $past(phase) == PH_SLOT_TX) |-> ($past(bit_stb) && !$past(bit_val)));
endmodule

bind tag_link_ctrl tag_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
  .slot_match(slot_match), .rxf_wr(rxf_wr), .txf_rd(txf_rd), .tx_en(tx_en),
  .phase(phase), .sync_hit(sync_hit)
);

// File: tb/sim_tag_link_ctrl.sv
module sim_tag_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] SYNC = 13'b1111100110101;
  // {lead zeros in align, flipped bit index (15 = none), expected phase}
  localparam logic [14:0] VEC [6] = '{
    {8'd0,  4'd15, 3'd3},
    {8'd5,  4'd15, 3'd3},
    {8'd63, 4'd15, 3'd3},
    {8'd64, 4'd15, 3'd0},
    {8'd0,  4'd3,  3'd0},
    {8'd20, 4'd12, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_stb = 1'b0, bit_val = 1'b0, pre_found = 1'b0, slot_match = 1'b0;
  logic txf_empty;
  logic [127:0] txf_data;
  logic rxf_wr, rxf_bit, txf_rd, tx_en, tx_bit;
  logic [2:0] phase;

  int total = 0, bad = 0;
  int rx_n = 0, tx_n = 0, rd_n = 0, head = 0, nblk = 0;
  logic pend = 1'b0;
  logic [127:0] blk [2];
  logic rx_log [256];
  logic tx_log [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign txf_empty = (head >= nblk);
  assign txf_data  = (head < nblk && head < 2) ? blk[head] : '0;

  tag_link_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .pre_found(pre_found), .slot_match(slot_match), .txf_empty(txf_empty),
    .txf_data(txf_data), .rxf_wr(rxf_wr), .rxf_bit(rxf_bit), .txf_rd(txf_rd),
    .tx_en(tx_en), .tx_bit(tx_bit), .phase(phase)
  );

  always @(negedge clk) begin
    if (rxf_wr && rx_n < 256) begin rx_log[rx_n] = rxf_bit; rx_n++; end
    if (pend) head++;
    pend = txf_rd;
    if (txf_rd) rd_n++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic b);
    @(negedge clk);
    bit_stb = 1'b1; bit_val = b;
    if (tx_en && tx_n < 256) begin tx_log[tx_n] = tx_bit; tx_n++; end
    @(negedge clk);
    bit_stb = 1'b0; bit_val = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pre_found = 1'b0; slot_match = 1'b0;
    idle(3);
    rst_n = 1'b1;
    rx_n = 0; tx_n = 0; rd_n = 0; head = 0; pend = 1'b0;
    idle(1);
  endtask

  task automatic enter_align();
    @(negedge clk) pre_found = 1'b1;
    @(negedge clk) pre_found = 1'b0;
    for (int i = 0; i < 63; i++) strobe(1'b0);
  endtask

  function automatic logic rxpat(input int i);
    return logic'(((i * 5) >> 1) ^ i);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mis;
    blk[0] = {4{32'hA5C3_0F96}};
    blk[1] = {4{32'h1234_8001}};
    nblk = 0;

    // vector table: sync window edges (R3, R4)
    for (int v = 0; v < 6; v++) begin
      int lead, flip, tot;
      lead = int'(VEC[v][14:7]); flip = int'(VEC[v][6:3]); tot = 0;
      do_reset();
      enter_align();
      for (int i = 0; i < lead && tot < 76; i++) begin strobe(1'b0); tot++; end
      for (int k = 12; k >= 0; k--) begin
        if (tot < 76 && phase == 3'd2) begin
          strobe(SYNC[k] ^ (k == flip)); tot++;
        end
      end
      while (phase == 3'd2 && tot < 76) begin strobe(1'b0); tot++; end
      check($sformatf("R3/R4 vector %0d phase", v), int'(phase), int'(VEC[v][2:0]));
    end

    // reset state R1
    do_reset();
    check("R1 phase", int'(phase), 0);
    check("R1 rxf_wr", int'(rxf_wr), 0);
    check("R1 tx_en/txf_rd", int'(tx_en | txf_rd), 0);

    // slot_match with nothing held in hunt has no effect on phase (R7)
    nblk = 2;
    @(negedge clk) slot_match = 1'b1;
    @(negedge clk) slot_match = 1'b0;
    check("R7 slot_match ignored in hunt", int'(phase), 0);

    // R2 detect duration
    @(negedge clk) pre_found = 1'b1;
    @(negedge clk) pre_found = 1'b0;
    check("R2 enter detect", int'(phase), 1);
    for (int i = 0; i < 62; i++) strobe(1'b1);
    check("R2 still detect after 62", int'(phase), 1);
    strobe(1'b0);
    check("R2 align after 63", int'(phase), 2);
    for (int k = 12; k >= 0; k--) strobe(SYNC[k]);
    check("R3 locked", int'(phase), 3);
    idle(2);
    check("R2 no writes before receive", rx_n, 0);

    // R5 receive
    for (int i = 0; i < 128; i++) strobe(rxpat(i));
    idle(2);
    check("R5 write count", rx_n, 128);
    mis = 0;
    for (int i = 0; i < 128; i++) if (rx_log[i] !== rxpat(i)) mis++;
    check("R5 write data mismatches", mis, 0);
    check("R6 single pop", rd_n, 1);
    check("R5 phase slot wait", int'(phase), 4);

    // R7/R8 first block
    for (int i = 0; i < 3; i++) strobe(1'b0);
    check("R7 waits without slot", int'(phase), 4);
    @(negedge clk) slot_match = 1'b1;
    @(negedge clk) slot_match = 1'b0;
    check("R7 send entered", int'(phase), 5);
    check("R8 tx_en high", int'(tx_en), 1);
    tx_n = 0;
    for (int i = 0; i < 128; i++) strobe(1'b0);
    mis = 0;
    for (int i = 0; i < 128; i++) if (tx_log[i] !== blk[0][127-i]) mis++;
    check("R8 block0 MSB-first mismatches", mis, 0);
    idle(2);
    check("R6 second pop", rd_n, 2);
    check("R8 back to slot wait", int'(phase), 4);

    // second block then drain
    @(negedge clk) slot_match = 1'b1;
    @(negedge clk) slot_match = 1'b0;
    tx_n = 0;
    for (int i = 0; i < 128; i++) strobe(1'b0);
    mis = 0;
    for (int i = 0; i < 128; i++) if (tx_log[i] !== blk[1][127-i]) mis++;
    check("R8 block1 MSB-first mismatches", mis, 0);
    idle(2);
    check("R9 drained phase", int'(phase), 6);
    check("R9 tx_en low", int'(tx_en), 0);

    // R10 guard with restart
    for (int i = 0; i < 10; i++) strobe(1'b0);
    strobe(1'b1);
    for (int i = 0; i < 19; i++) strobe(1'b0);
    check("R10 guard restarted", int'(phase), 6);
    strobe(1'b0);
    check("R10 refill entered", int'(phase), 7);

    // R11 refill
    idle(1);
    rx_n = 0;
    for (int i = 0; i < 128; i++) strobe(~rxpat(i));
    idle(2);
    check("R11 write count", rx_n, 128);
    mis = 0;
    for (int i = 0; i < 128; i++) if (rx_log[i] !== ~rxpat(i)) mis++;
    check("R11 write data mismatches", mis, 0);
    check("R11/R9 phase after refill, fifo empty", int'(phase), 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule